// File: doc/BRIEF.md
# Address-Framed Three-Wire Serial Slave

This block is the slave end of a three-wire serial link with a chip-enable line, a bit clock and a data-in line, plus one open-drain data-out line. All four lines are sampled in the system clock domain. The host first shifts in an address byte while chip enable is low. It then raises chip enable for the data phase. One address starts a write of display and control data. A second address starts a read of the key matrix state. Any other address leaves the block idle until chip enable falls again.

The 75 display bits and nine control bits do not fit in one frame, so a write is split across two 52-bit frames. A two-bit direction code at the tail of each frame says which frame it is. A frame takes effect only when chip enable falls, and only if exactly 52 bits arrived.

After power-on the block holds a system reset. That reset is released by the chip-enable fall that completes the second of the two frame types. The serial interface itself keeps working during this reset. The data-out wire has two jobs. Between transfers it signals a pending key read request by going low. During a read it carries the key bits followed by the sleep-acknowledge bit.

Top module: `serial_disp_slave`

## Requirements
- R1: The address is the last 8 bits sampled on rising `cl_i` edges while `ce_i` is low, least significant bit first. When `ce_i` rises, address 0x42 opens a write and 0x43 opens a read. Any other address is ignored: no output register changes, and `do_o` stays high while `ce_i` is high.
- R2: During a write, data bits are sampled on rising `cl_i` edges while `ce_i` is high. A frame is applied on the falling edge of `ce_i`, and only if exactly 52 bits arrived. A frame of 51 or 53 bits changes nothing.
- R3: Bits are numbered 1 to 52 in arrival order. Bit 51 is the first direction bit and bit 52 is the second. Frame one has both direction bits equal to 0. In frame one, bits 1..39 load display bits 0..38 of `disp_o`. Bits 40..48 load, in this order: sleep[0], sleep[1], key_sel[0], key_sel[1], port_sel[0], port_sel[1], port_sel[2], `seg_off_o` and `bias_half_o`.
- R4: Frame two has first direction bit 1 and second direction bit 0. In frame two, bits 1..36 load display bits 39..74 of `disp_o`, and the control outputs are kept. A frame whose direction pair is 11 or 01 (first, second) is discarded.
- R5: When a read opens, `do_o` shows key bit 0 from the next clock onward. Each falling `cl_i` edge advances the output by one position: key bits 0..29, then the sleep-acknowledge bit, then a constant 1. The sleep-acknowledge bit is 1 when either sleep bit is set and 0 when both are clear.
- R6: `rst_ni` sets `sys_rst_o` to 1. Writes are accepted while `sys_rst_o` is 1. `sys_rst_o` clears on the falling `ce_i` that applies whichever frame type arrives second, once both types have been received. After that it stays 0.
- R7: While `ce_i` is low and no read is running, `do_o` is low exactly when `key_req_i` is 1 and `sys_rst_o` is 0. While `ce_i` is high outside a read, `do_o` is high.
- R8: `key_rd_done_o` pulses for one clock after `ce_i` falls to end a read, provided `sys_rst_o` is 0.
- R9: A read opened while `key_req_i` is 0 returns 0 for all 30 key bits. The sleep-acknowledge bit stays valid.
- R10: While `sys_rst_o` is 1, `do_o` is high throughout, including during a read, and no done pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| ce_i | input | 1 | Chip enable: low for the address phase, high for the data phase |
| cl_i | input | 1 | Serial bit clock |
| di_i | input | 1 | Serial data in |
| key_data_i | input | 30 | Debounced key matrix state |
| key_req_i | input | 1 | Key scanner requests a read |
| do_o | output | 1 | Serial data out level (1 = released) |
| key_rd_done_o | output | 1 | One-cycle pulse when a read completes |
| disp_o | output | 75 | Latched display bits |
| sleep_o | output | 2 | Sleep control bits |
| key_sel_o | output | 2 | Key-scan or segment selection bits |
| port_sel_o | output | 3 | Segment or general-output selection bits |
| seg_off_o | output | 1 | All segments off |
| bias_half_o | output | 1 | Half-bias drive select |
| sys_rst_o | output | 1 | System reset still held |

## Verification
The bench targets several corner cases; each names what a faulty design would do.
- Frame length: it sends frames of 51 and 53 bits. A counter that latched on "at least" or "at most" the correct length would corrupt the display.
- Direction codes: it sends both invalid direction codes. A decoder that looked at only one direction bit would overwrite one half of the display.
- Reset release: it writes frame one alone and checks that the system reset is still held. A design that released on any single valid frame would fail here.
- Read framing: it reads key data both during reset and without a pending request. A design that missed the output masking, advanced the serializer on the wrong clock edge, or dropped the trailing sleep bit would show the wrong bit pattern on `do_o`.

// File: rtl/sds_pkg.sv
package sds_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_WR, PH_RD, PH_IGN} phase_e;

  // control field order follows frame-one arrival order, first bit in the LSB
  typedef struct packed {
    logic       bias_half;
    logic       seg_off;
    logic [2:0] port_sel;
    logic [1:0] key_sel;
    logic [1:0] sleep;
  } ctrl_t;

  localparam int unsigned CTRL_BITS = $bits(ctrl_t);
  // direction code as {second bit, first bit}
  localparam logic [1:0] DIR_F1 = 2'b00;
  localparam logic [1:0] DIR_F2 = 2'b01;
endpackage

// File: rtl/sds_rx.sv
module sds_rx
  import sds_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 52,
  parameter int unsigned ADDR_BITS  = 8,
  parameter logic [7:0]  ADDR_WR    = 8'h42,
  parameter logic [7:0]  ADDR_RD    = 8'h43
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ce_i,
  input  logic                  cl_i,
  input  logic                  di_i,
  output logic                  ce_q_o,
  output logic                  ce_fall_o,
  output logic                  cl_fall_o,
  output logic                  rd_start_o,
  output logic                  rd_active_o,
  output logic                  wr_ok_o,
  output logic [FRAME_BITS-1:0] frame_o
);
  localparam int unsigned CW = $clog2(FRAME_BITS + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_BITS);
  localparam logic [CW-1:0] CNT_MAX  = CW'(FRAME_BITS + 1);

  logic                  ce_q, cl_q;
  logic [ADDR_BITS-1:0]  addr_q;
  phase_e                phase_q;
  logic [FRAME_BITS-1:0] frame_q;
  logic [CW-1:0]         cnt_q;
  logic                  ce_rise, ce_fall, cl_rise, cl_fall;

  assign ce_rise = ce_i & ~ce_q;
  assign ce_fall = ~ce_i & ce_q;
  assign cl_rise = cl_i & ~cl_q;
  assign cl_fall = ~cl_i & cl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q    <= 1'b0;
      cl_q    <= 1'b0;
      addr_q  <= '0;
      phase_q <= PH_IDLE;
      frame_q <= '0;
      cnt_q   <= '0;
    end else begin
      ce_q <= ce_i;
      cl_q <= cl_i;
      if (!ce_i && cl_rise) addr_q <= {di_i, addr_q[ADDR_BITS-1:1]};
      if (ce_rise) begin
        cnt_q <= '0;
        if (addr_q == ADDR_BITS'(ADDR_WR))      phase_q <= PH_WR;
        else if (addr_q == ADDR_BITS'(ADDR_RD)) phase_q <= PH_RD;
        else                                    phase_q <= PH_IGN;
      end else if (ce_fall) begin
        phase_q <= PH_IDLE;
      end else if (ce_i && cl_rise && phase_q == PH_WR) begin
        frame_q <= {di_i, frame_q[FRAME_BITS-1:1]};
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ce_q_o      = ce_q;
  assign ce_fall_o   = ce_fall;
  assign cl_fall_o   = cl_fall;
  assign rd_start_o  = ce_rise && (addr_q == ADDR_BITS'(ADDR_RD));
  assign rd_active_o = (phase_q == PH_RD);
  assign wr_ok_o     = (phase_q == PH_WR) && (cnt_q == CNT_FULL);
  assign frame_o     = frame_q;

  AST_RD_NEEDS_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_active_o |-> ce_q); // R1
  AST_ADDR_HELD_IN_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_q && ce_i) |=> $stable(addr_q)); // R1
endmodule

// File: rtl/sds_regs.sv
module sds_regs
  import sds_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 52,
  parameter int unsigned DISP_BITS  = 75,
  parameter int unsigned D1_BITS    = 39
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ce_fall_i,
  input  logic                  wr_ok_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  output logic [DISP_BITS-1:0]  disp_o,
  output ctrl_t                 ctrl_o,
  output logic                  sys_rst_o
);
  localparam int unsigned D2_BITS = DISP_BITS - D1_BITS;

  logic [DISP_BITS-1:0] disp_q;
  ctrl_t                ctrl_q;
  logic                 got1_q, got2_q, rst_q;
  logic [1:0]           dir;
  logic                 take1, take2;

  assign dir   = {frame_i[FRAME_BITS-1], frame_i[FRAME_BITS-2]};
  assign take1 = ce_fall_i && wr_ok_i && (dir == DIR_F1);
  assign take2 = ce_fall_i && wr_ok_i && (dir == DIR_F2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_q <= '0;
      ctrl_q <= '0;
      got1_q <= 1'b0;
      got2_q <= 1'b0;
      rst_q  <= 1'b1;
    end else begin
      if (take1) begin
        disp_q[D1_BITS-1:0] <= frame_i[D1_BITS-1:0];
        ctrl_q              <= frame_i[D1_BITS +: CTRL_BITS];
        got1_q              <= 1'b1;
        if (got2_q) rst_q <= 1'b0;
      end
      if (take2) begin
        disp_q[DISP_BITS-1:D1_BITS] <= frame_i[D2_BITS-1:0];
        got2_q                      <= 1'b1;
        if (got1_q) rst_q <= 1'b0;
      end
    end
  end

  assign disp_o    = disp_q;
  assign ctrl_o    = ctrl_q;
  assign sys_rst_o = rst_q;

  AST_DISP_ONLY_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_fall_i |=> $stable(disp_q)); // R2
  AST_RST_RELEASE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_q && !ce_fall_i) |=> rst_q); // R6
  AST_RST_STAYS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_q |=> !rst_q); // R6
endmodule

// File: rtl/sds_tx.sv
module sds_tx #(
  parameter int unsigned KEY_BITS = 30
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_start_i,
  input  logic                rd_active_i,
  input  logic                cl_fall_i,
  input  logic                ce_q_i,
  input  logic                ce_fall_i,
  input  logic                sys_rst_i,
  input  logic                sleep_any_i,
  input  logic                key_req_i,
  input  logic [KEY_BITS-1:0] key_data_i,
  output logic                do_o,
  output logic                rd_done_o
);
  logic [KEY_BITS:0] sh_q;
  logic              rd_done_q;
  logic              req_ok;

  assign req_ok = key_req_i && !sys_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '1;
      rd_done_q <= 1'b0;
    end else begin
      rd_done_q <= ce_fall_i && rd_active_i && !sys_rst_i;
      if (rd_start_i)
        sh_q <= {sleep_any_i, req_ok ? key_data_i : {KEY_BITS{1'b0}}};
      else if (rd_active_i && cl_fall_i)
        sh_q <= {1'b1, sh_q[KEY_BITS:1]};
    end
  end

  always_comb begin
    if (sys_rst_i)        do_o = 1'b1;
    else if (rd_active_i) do_o = sh_q[0];
    else if (ce_q_i)      do_o = 1'b1;
    else                  do_o = ~key_req_i;
  end

  assign rd_done_o = rd_done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_q |=> !rd_done_q); // R8
endmodule

// File: rtl/serial_disp_slave.sv
module serial_disp_slave
  import sds_pkg::*;
#(
  parameter int unsigned DISP_BITS  = 75,
  parameter int unsigned D1_BITS    = 39,
  parameter int unsigned KEY_BITS   = 30,
  parameter int unsigned FRAME_BITS = 52,
  parameter logic [7:0]  ADDR_WR    = 8'h42,
  parameter logic [7:0]  ADDR_RD    = 8'h43
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ce_i,
  input  logic                 cl_i,
  input  logic                 di_i,
  input  logic [KEY_BITS-1:0]  key_data_i,
  input  logic                 key_req_i,
  output logic                 do_o,
  output logic                 key_rd_done_o,
  output logic [DISP_BITS-1:0] disp_o,
  output logic [1:0]           sleep_o,
  output logic [1:0]           key_sel_o,
  output logic [2:0]           port_sel_o,
  output logic                 seg_off_o,
  output logic                 bias_half_o,
  output logic                 sys_rst_o
);
  logic                  ce_q, ce_fall, cl_fall, rd_start, rd_active, wr_ok;
  logic [FRAME_BITS-1:0] frame;
  ctrl_t                 ctrl;
  logic                  sys_rst;

  sds_rx #(
    .FRAME_BITS(FRAME_BITS), .ADDR_BITS(8), .ADDR_WR(ADDR_WR), .ADDR_RD(ADDR_RD)
  ) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .cl_i(cl_i), .di_i(di_i),
    .ce_q_o(ce_q), .ce_fall_o(ce_fall), .cl_fall_o(cl_fall),
    .rd_start_o(rd_start), .rd_active_o(rd_active), .wr_ok_o(wr_ok), .frame_o(frame)
  );

  sds_regs #(
    .FRAME_BITS(FRAME_BITS), .DISP_BITS(DISP_BITS), .D1_BITS(D1_BITS)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_fall_i(ce_fall), .wr_ok_i(wr_ok),
    .frame_i(frame), .disp_o(disp_o), .ctrl_o(ctrl), .sys_rst_o(sys_rst)
  );

  sds_tx #(.KEY_BITS(KEY_BITS)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_start_i(rd_start), .rd_active_i(rd_active),
    .cl_fall_i(cl_fall), .ce_q_i(ce_q), .ce_fall_i(ce_fall), .sys_rst_i(sys_rst),
    .sleep_any_i(|ctrl.sleep), .key_req_i(key_req_i), .key_data_i(key_data_i),
    .do_o(do_o), .rd_done_o(key_rd_done_o)
  );

  assign sleep_o     = ctrl.sleep;
  assign key_sel_o   = ctrl.key_sel;
  assign port_sel_o  = ctrl.port_sel;
  assign seg_off_o   = ctrl.seg_off;
  assign bias_half_o = ctrl.bias_half;
  assign sys_rst_o   = sys_rst;

  AST_DO_HIGH_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst |-> do_o); // R10
  AST_NO_DONE_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst && $past(sys_rst)) |-> !key_rd_done_o); // R10
endmodule

// File: tb/tb_serial_disp_slave.sv
module tb_serial_disp_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b0, cl = 1'b0, di = 1'b0;
  logic [29:0] key_data = '0;
  logic        key_req = 1'b0;
  logic        do_w, done_w, sys_rst_w, seg_off_w, bias_w;
  logic [74:0] disp_w;
  logic [1:0]  sleep_w, key_sel_w;
  logic [2:0]  port_sel_w;

  int n_chk = 0, n_bad = 0, done_cnt = 0;
  bit finished = 1'b0;
  logic mid_do;
  logic [30:0] got;
  logic tail;

  always #2.5 clk = ~clk;

  serial_disp_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .cl_i(cl), .di_i(di),
    .key_data_i(key_data), .key_req_i(key_req), .do_o(do_w), .key_rd_done_o(done_w),
    .disp_o(disp_w), .sleep_o(sleep_w), .key_sel_o(key_sel_w), .port_sel_o(port_sel_w),
    .seg_off_o(seg_off_w), .bias_half_o(bias_w), .sys_rst_o(sys_rst_w)
  );

  always @(negedge clk) if (rst_n && done_w) done_cnt++;

  // {ctrl[8:0] = bias,segoff,p2,p1,p0,k1,k0,s1,s0 ; disp[38:0]}
  localparam logic [47:0] WR_TAB [4] = '{
    {9'h000, 39'h00_0000_0001},
    {9'h1FF, 39'h7F_FFFF_FFFF},
    {9'h0AA, 39'h55_5555_5555},
    {9'h155, 39'h2A_AAAA_AAAA}
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cl_bit(input logic d);
    @(negedge clk) di = d;
    @(negedge clk) cl = 1'b1;
    repeat (2) @(negedge clk);
    cl = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_addr(input logic [7:0] a);
    for (int i = 0; i < 8; i++) cl_bit(a[i]);
    @(negedge clk) ce = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] a, input logic [63:0] f, input int n);
    send_addr(a);
    for (int i = 0; i < n; i++) cl_bit(f[i]);
    mid_do = do_w;
    @(negedge clk) ce = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [63:0] mk_f1(input logic [8:0] c, input logic [38:0] d);
    return {12'b0, 1'b0, 1'b0, 2'b00, c, d};
  endfunction

  function automatic logic [63:0] mk_f2(input logic [35:0] d);
    return {12'b0, 1'b0, 1'b1, 14'b0, d};
  endfunction

  function automatic logic [8:0] ctrl_now();
    return {bias_w, seg_off_w, port_sel_w, key_sel_w, sleep_w};
  endfunction

  task automatic read_keys();
    send_addr(8'h43);
    got[0] = do_w;
    for (int i = 1; i <= 31; i++) begin
      @(negedge clk) cl = 1'b1;
      repeat (2) @(negedge clk);
      cl = 1'b0;
      repeat (2) @(negedge clk);
      if (i < 31) got[i] = do_w;
      else tail = do_w;
    end
    @(negedge clk) ce = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [74:0] ref_disp;
    logic [8:0]  ref_ctrl;
    int          d0;
    key_req = 1'b1;
    key_data = 30'h1234_5678;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // reset state
    chk("R6 reset held", sys_rst_w, 1);
    chk("R10 do high in reset", do_w, 1);
    chk("R6 disp reset", disp_w, 0);

    // read during system reset: all ones, no done pulse
    d0 = done_cnt;
    read_keys();
    chk("R10 read data in reset", {tail, got}, {1'b1, 31'h7FFF_FFFF});
    chk("R10 no done in reset", done_cnt - d0, 0);

    // frame one alone keeps reset
    xfer(8'h42, mk_f1(9'h000, 39'h11_2233_4455), 52);
    chk("R6 transfer during reset", disp_w[38:0], 39'h11_2233_4455);
    chk("R6 still held after one frame", sys_rst_w, 1);
    // frame two releases
    xfer(8'h42, mk_f2(36'h9_8765_4321), 52);
    chk("R4 frame two data", disp_w[74:39], 36'h9_8765_4321);
    chk("R6 released", sys_rst_w, 0);
    chk("R4 frame one kept", disp_w[38:0], 39'h11_2233_4455);

    // table walk of frame-one contents
    for (int k = 0; k < 4; k++) begin
      xfer(8'h42, mk_f1(WR_TAB[k][47:39], WR_TAB[k][38:0]), 52);
      chk("R3 disp low", disp_w[38:0], WR_TAB[k][38:0]);
      chk("R3 ctrl fields", ctrl_now(), WR_TAB[k][47:39]);
      chk("R4 disp high kept", disp_w[74:39], 36'h9_8765_4321);
    end
    ref_disp = disp_w;
    ref_ctrl = ctrl_now();

    // length errors
    xfer(8'h42, mk_f1(9'h0F0, 39'h0F_0F0F_0F0F), 51);
    chk("R2 short frame ignored", {ctrl_now(), disp_w}, {ref_ctrl, ref_disp});
    xfer(8'h42, {mk_f1(9'h0F0, 39'h0F_0F0F_0F0F)[62:0], 1'b1}, 53);
    chk("R2 long frame ignored", {ctrl_now(), disp_w}, {ref_ctrl, ref_disp});
    // bad direction codes
    xfer(8'h42, mk_f1(9'h0F0, 39'h0F_0F0F_0F0F) | (64'h3 << 50), 52);
    chk("R4 dir 11 rejected", {ctrl_now(), disp_w}, {ref_ctrl, ref_disp});
    xfer(8'h42, mk_f1(9'h0F0, 39'h0F_0F0F_0F0F) | (64'h1 << 51), 52);
    chk("R4 dir 01 rejected", {ctrl_now(), disp_w}, {ref_ctrl, ref_disp});
    // wrong address
    key_req = 1'b1;
    xfer(8'h44, mk_f1(9'h0F0, 39'h0F_0F0F_0F0F), 52);
    chk("R1 wrong address ignored", {ctrl_now(), disp_w}, {ref_ctrl, ref_disp});
    chk("R7 do high with ce high", mid_do, 1);
    xfer(8'h42, mk_f1(9'h0F0, 39'h0F_0F0F_0F0F), 52);
    chk("R1 write address accepted", disp_w[38:0], 39'h0F_0F0F_0F0F);

    // request signalling with ce low
    key_req = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 request drives low", do_w, 0);
    key_req = 1'b0;
    @(negedge clk);
    chk("R7 no request high", do_w, 1);

    // read with sleep set (S1)
    xfer(8'h42, mk_f1(9'h002, 39'h0), 52);
    key_req = 1'b1;
    key_data = 30'h2BAD_1E0F;
    d0 = done_cnt;
    read_keys();
    chk("R5 read bits with sleep ack 1", got, {1'b1, 30'h2BAD_1E0F});
    chk("R5 tail released", tail, 1);
    chk("R8 done pulse", done_cnt - d0, 1);

    // read with no pending request, sleep clear
    xfer(8'h42, mk_f1(9'h000, 39'h0), 52);
    key_req = 1'b0;
    d0 = done_cnt;
    read_keys();
    chk("R9 keys zero without request", got, {1'b0, 30'h0});
    chk("R8 done pulse second", done_cnt - d0, 1);

    // read with request and sleep clear
    key_req = 1'b1;
    key_data = 30'h0000_0001;
    read_keys();
    chk("R5 sleep ack 0", got, {1'b0, 30'h0000_0001});

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule